// File: doc/BRIEF.md
# SDRAM Read Return Aligner with Byte Masking

This block sits in a memory controller beside the command scheduler. Each time the scheduler issues a READ it pulses a strobe. From that strobe, the programmed CAS latency and the burst length code, the block works out in which cycles the memory will drive its data pins. It captures the 16-bit data in exactly those cycles. It then hands the word on with a valid flag and a per-byte valid flag, and a lane masked by the byte-mask pins reads as zero.

The beat schedule is truncated in two ways. A terminate strobe stops the schedule, and the read ends with the beat that arrives CAS latency minus one cycles after the strobe. A new READ cancels the beats still owed by the old one and starts its own schedule. The block also reports when the memory is driving the bus. It raises a hold flag for that cycle and the one after it, so the scheduler can keep a WRITE off the bus until a turnaround cycle has passed.

Top module: `rd_align_top`

## Requirements
- R1: An active-low asynchronous reset clears every output to zero and cancels any beats still scheduled, including a full-page read.
- R2: For a READ strobe in cycle t with CAS latency CL (casLat values 1, 2 or 3), the first beat is driven on dqIn in cycle t+CL and appears on rdData with rdValid high in cycle t+CL+1.
- R3: blCode 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats in consecutive cycles. blCode 7 gives a full-page burst that runs until it is cut short. Codes 4 to 6 give a single beat.
- R4: A dqm bit sampled in cycle j masks its lane in the data of cycle j+2, with bit 0 for bits 7:0 and bit 1 for bits 15:8. A masked lane has its byteValid bit low and its rdData byte zero, and the other lane is unaffected.
- R5: A burstStop strobe in cycle s (with no READ in that cycle) keeps the beat that is driven in cycle s+CL-1 and removes every later beat.
- R6: A READ that arrives while a burst is in progress drops all beats the earlier READ still owed. Its own beats follow with the CAS-latency timing of R2.
- R7: busDriven is high in exactly the cycles in which the memory drives a read beat.
- R8: wrHold is high in every cycle where busDriven is high, and in the cycle that follows one.
- R9: When rdValid is low, rdData and byteValid are zero.
- R10: READ strobes in consecutive cycles are all accepted, and the beats run back to back with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| rdIssue | input | 1 | A READ command is issued in this cycle |
| burstStop | input | 1 | A burst-terminate command is issued in this cycle |
| casLat | input | 2 | CAS latency in cycles, 1 to 3 |
| blCode | input | 3 | Burst length code, sampled with rdIssue |
| dqm | input | 2 | Byte mask for reads, takes effect two cycles later |
| dqIn | input | 16 | Data pins from the memory |
| rdData | output | 16 | Captured read word, masked lanes zero |
| rdValid | output | 1 | rdData holds a read beat |
| byteValid | output | 2 | Per-lane valid, low for masked lanes |
| busDriven | output | 1 | The memory is driving the data pins this cycle |
| wrHold | output | 1 | A WRITE must not use the bus this cycle |

## Verification
The embedded properties assume that casLat holds a value from 1 to 3 and does not change while a burst is in flight. They also assume that a terminate strobe and a READ strobe never arrive in the same cycle, and that every full-page read is ended by a terminate or by another READ. The stimulus sets casLat only between scenarios, after enough idle cycles to drain the pipeline. It places each terminate and each second READ in separate cycles, and each full-page row carries its own terminate. Reset is applied once at the start and once in the middle of an unterminated full-page burst.

// File: rtl/rd_align_pkg.sv
package rd_align_pkg;
  // Byte lanes on the data pins and bits per lane
  localparam int unsigned LANES  = 2;
  localparam int unsigned LANE_W = 8;

  // Strobes from the schedule to the capture datapath
  typedef struct packed {
    logic             capture;
    logic [LANES-1:0] laneEn;
  } rdStrobe_t;
endpackage

// File: rtl/rd_align_ctl.sv
module rd_align_ctl
  import rd_align_pkg::*;
#(
  parameter int unsigned MAX_CL  = 3,
  parameter int unsigned DQM_LAT = 2,
  parameter int unsigned MAX_BL  = 8,
  parameter int unsigned BL_W    = 3,
  parameter int unsigned CL_W    = $clog2(MAX_CL + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdIssue,
  input  logic             burstStop,
  input  logic [CL_W-1:0]  casLat,
  input  logic [BL_W-1:0]  blCode,
  input  logic [LANES-1:0] dqm,
  output rdStrobe_t        strobe,
  output logic             busDriven,
  output logic             wrHold
);
  localparam int unsigned CNT_W    = $clog2(MAX_BL);
  localparam int unsigned MAX_CODE = $clog2(MAX_BL);
  localparam logic [BL_W-1:0] FULL_CODE = {BL_W{1'b1}};

  logic [CNT_W-1:0] remCnt;
  logic [CNT_W-1:0] blMinus1;
  logic             fullRun;
  logic             slotNow;
  logic [MAX_CL:1]  slotPipe;
  logic             tap;
  logic             tapPrev;
  logic [LANES-1:0] dqmDly [DQM_LAT];

  // Beats still owed after the first one
  always_comb begin
    if (blCode <= BL_W'(MAX_CODE))
      blMinus1 = CNT_W'((32'd1 << blCode) - 32'd1);
    else
      blMinus1 = '0;
  end

  // A beat is owed in this command-side cycle
  assign slotNow = rdIssue | (!burstStop & (fullRun | (remCnt != '0)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remCnt  <= '0;
      fullRun <= 1'b0;
    end else if (rdIssue) begin
      fullRun <= (blCode == FULL_CODE);
      remCnt  <= (blCode == FULL_CODE) ? '0 : blMinus1;
    end else if (burstStop) begin
      fullRun <= 1'b0;
      remCnt  <= '0;
    end else if (!fullRun && remCnt != '0) begin
      remCnt  <= remCnt - 1'b1;
    end
  end

  // Latency line: slotPipe[k] holds slotNow from k cycles back
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotPipe <= '0;
      tapPrev  <= 1'b0;
    end else begin
      slotPipe <= {slotPipe[MAX_CL-1:1], slotNow};
      tapPrev  <= tap;
    end
  end

  always_comb begin
    tap = slotPipe[1];
    for (int k = 2; k <= MAX_CL; k++)
      if (casLat == CL_W'(k)) tap = slotPipe[k];
  end

  // Read mask delay line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DQM_LAT; i++) dqmDly[i] <= '0;
    end else begin
      dqmDly[0] <= dqm;
      for (int i = 1; i < DQM_LAT; i++) dqmDly[i] <= dqmDly[i-1];
    end
  end

  assign strobe.capture = tap;
  assign strobe.laneEn  = ~dqmDly[DQM_LAT-1];
  assign busDriven      = tap;
  assign wrHold         = tap | tapPrev;

  // R2
  issue_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdIssue |=> slotPipe[1]);

  // R5
  stop_cut_chk: assert property (@(posedge clk) disable iff (!rstN)
    (burstStop && !rdIssue) |=> !slotPipe[1]);

  // R3
  one_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdIssue && blCode == '0) ##1 !rdIssue |-> !slotNow);

  // R8
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDriven |-> wrHold);

  // R8
  hold_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busDriven) |-> wrHold);
endmodule

// File: rtl/rd_align_dp.sv
module rd_align_dp
  import rd_align_pkg::*;
#(
  parameter int unsigned DQ_W = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  rdStrobe_t        strobe,
  input  logic [DQ_W-1:0]  dqIn,
  output logic [DQ_W-1:0]  rdData,
  output logic             rdValid,
  output logic [LANES-1:0] byteValid
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= strobe.capture;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic keep;
    assign keep = strobe.capture & strobe.laneEn[g];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        byteValid[g]                  <= 1'b0;
        rdData[g*LANE_W +: LANE_W]    <= '0;
      end else begin
        byteValid[g]                  <= keep;
        rdData[g*LANE_W +: LANE_W]    <= keep ? dqIn[g*LANE_W +: LANE_W] : '0;
      end
    end
  end

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (byteValid == '0 && rdData == '0));
endmodule

// File: rtl/rd_align_top.sv
module rd_align_top
  import rd_align_pkg::*;
#(
  parameter int unsigned MAX_CL  = 3,
  parameter int unsigned DQM_LAT = 2,
  parameter int unsigned MAX_BL  = 8,
  parameter int unsigned BL_W    = 3,
  parameter int unsigned CL_W    = $clog2(MAX_CL + 1),
  parameter int unsigned DQ_W    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdIssue,
  input  logic             burstStop,
  input  logic [CL_W-1:0]  casLat,
  input  logic [BL_W-1:0]  blCode,
  input  logic [LANES-1:0] dqm,
  input  logic [DQ_W-1:0]  dqIn,
  output logic [DQ_W-1:0]  rdData,
  output logic             rdValid,
  output logic [LANES-1:0] byteValid,
  output logic             busDriven,
  output logic             wrHold
);
  rdStrobe_t strobe;

  rd_align_ctl #(
    .MAX_CL(MAX_CL), .DQM_LAT(DQM_LAT), .MAX_BL(MAX_BL), .BL_W(BL_W), .CL_W(CL_W)
  ) uCtl (
    .clk(clk), .rstN(rstN), .rdIssue(rdIssue), .burstStop(burstStop),
    .casLat(casLat), .blCode(blCode), .dqm(dqm),
    .strobe(strobe), .busDriven(busDriven), .wrHold(wrHold)
  );

  rd_align_dp #(.DQ_W(DQ_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dqIn(dqIn),
    .rdData(rdData), .rdValid(rdValid), .byteValid(byteValid)
  );

  // R7
  drive_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDriven |=> rdValid);

  // R7
  quiet_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busDriven |=> !rdValid);
endmodule

// File: tb/sim_rd_align_top.sv
`timescale 1ns/1ps
module sim_rd_align_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdIssue = 1'b0, burstStop = 1'b0;
  logic [1:0]  casLat = 2'd1;
  logic [2:0]  blCode = 3'd0;
  logic [1:0]  dqm = 2'b00;
  logic [15:0] dqIn = 16'h0;
  logic [15:0] rdData;
  logic        rdValid, busDriven, wrHold;
  logic [1:0]  byteValid;

  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  rd_align_top u0 (
    .clk(clk), .rstN(rstN), .rdIssue(rdIssue), .burstStop(burstStop),
    .casLat(casLat), .blCode(blCode), .dqm(dqm), .dqIn(dqIn),
    .rdData(rdData), .rdValid(rdValid), .byteValid(byteValid),
    .busDriven(busDriven), .wrHold(wrHold)
  );

  typedef struct packed {
    int cl; int bl; int stopAt; int rd2At; int bl2; int dqmAt; int dqmVal;
  } row_t;

  localparam int NROWS = 9;
  localparam row_t ROWS [NROWS] = '{
    '{1, 0, 0, 0, 0, 0, 0},   // R2 CL1 single beat
    '{2, 2, 0, 0, 0, 2, 1},   // R4 CL2 four beats, low lane masked on beat 2
    '{3, 3, 3, 0, 0, 3, 2},   // R5 CL3 eight beats cut to three, high lane masked
    '{3, 1, 0, 0, 0, 1, 3},   // R4 CL3 two beats, both lanes masked on beat 0
    '{2, 7, 6, 0, 0, 0, 0},   // R3 full page ended after six beats
    '{3, 3, 0, 2, 1, 0, 0},   // R6 second READ cuts the first
    '{1, 2, 0, 1, 0, 0, 0},   // R10 READs in consecutive cycles
    '{2, 3, 1, 0, 0, 0, 0},   // R5 terminate right after READ
    '{1, 5, 0, 0, 0, 0, 0}    // R3 reserved code gives one beat
  };

  function automatic int beats(int code);
    if (code <= 3) return 1 << code;
    if (code == 7) return 1000;
    return 1;
  endfunction

  function automatic bit slotOn(row_t r, int s);
    bit on;
    if (s < 0) return 1'b0;
    if (r.rd2At != 0 && s >= r.rd2At) on = (s - r.rd2At) < beats(r.bl2);
    else                              on = s < beats(r.bl);
    if (r.stopAt != 0 && s >= r.stopAt) on = 1'b0;
    return on;
  endfunction

  function automatic logic [15:0] dqAt(int m);
    return {8'(8'hA0 + m), 8'(8'h50 + m)};
  endfunction

  function automatic logic [1:0] dqmAt(row_t r, int m);
    return (m == r.dqmAt && m >= 0) ? 2'(r.dqmVal) : 2'b00;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, int m);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%h expected=%h", req, m, act, exp);
    end
  endtask

  task automatic checkZero(string req);
    check(req, {rdData, byteValid, rdValid, busDriven, wrHold}, 32'h0, -1);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rdIssue = 1'b0; burstStop = 1'b0; dqm = 2'b00; dqIn = 16'h0;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    checkZero("R1");
    rstN = 1'b1;
    idle(2);
    checkZero("R1");

    for (int ri = 0; ri < NROWS; ri++) begin
      row_t r = ROWS[ri];
      casLat = 2'(r.cl);
      idle(6);
      for (int m = 0; m < 16; m++) begin
        bit          vExp, dExp, hExp;
        logic [1:0]  bvExp;
        logic [15:0] datExp;
        @(negedge clk);
        vExp  = slotOn(r, m - 1 - r.cl);
        dExp  = slotOn(r, m - r.cl);
        hExp  = dExp | slotOn(r, m - 1 - r.cl);
        bvExp = vExp ? ~dqmAt(r, m - 3) : 2'b00;
        datExp = {bvExp[1] ? dqAt(m - 1)[15:8] : 8'h00,
                  bvExp[0] ? dqAt(m - 1)[7:0]  : 8'h00};
        // R2 R3 R4 R5 R6 R9 R10: captured beat, lane flags and data
        check("R2,R3,R4,R5,R6,R9,R10", {13'h0, rdValid, byteValid, rdData},
              {13'h0, vExp, bvExp, datExp}, m);
        check("R7", {31'h0, busDriven}, {31'h0, dExp}, m);
        check("R8", {31'h0, wrHold}, {31'h0, hExp}, m);
        rdIssue   = (m == 0) || (r.rd2At != 0 && m == r.rd2At);
        blCode    = (r.rd2At != 0 && m >= r.rd2At) ? 3'(r.bl2) : 3'(r.bl);
        burstStop = (r.stopAt != 0 && m == r.stopAt);
        dqm       = dqmAt(r, m);
        dqIn      = dqAt(m);
      end
    end

    // R1 reset in the middle of an unterminated full-page read
    casLat = 2'd1;
    idle(4);
    @(negedge clk);
    rdIssue = 1'b1; blCode = 3'd7; dqIn = 16'h1234;
    idle(3);
    check("R1", {31'h0, busDriven}, 32'h1, 0);
    rstN = 1'b0;
    @(negedge clk);
    checkZero("R1");
    rstN = 1'b1;
    idle(3);
    checkZero("R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule